// File: doc/BRIEF.md
# Paced Scan-List Sequencer

This block runs a multi-channel acquisition sequence for an analog front end. A host loads a queue of scan-list entries over a byte-wide write port. Each entry is 16 bits and takes two byte writes. The host also sets a 24-bit pacer divisor and a mode register, then controls the run through a command register whose action bits act as one-cycle pulses. Once armed, the sequencer walks the queue from entry 0. For every entry it raises a one-cycle conversion request that carries the entry's channel, gain, differential and external-selection fields.

Entries carrying a start mark hold until the next pacer tick. Unmarked entries issue on the cycle after the previous one. Marking every entry paces each conversion. Marking only the first entry paces whole scans and bursts the rest. In one-shot mode a single arm makes one pass through the queue. In continuous mode the pass repeats, with a wrap to entry 0, until a stop command arrives.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, busy, conv_req, scan_end and conv_done are all 0.
- R2: The queue port is address 0. An entry takes two writes there, low byte first, and is committed on the second write. Entry bit 14 is differential, bits 13:12 gain, bits 11:8 channel, bit 7 start mark, bits 5:4 external gain and bits 3:0 external channel. Bits 15 and 6 are ignored. Each conv_req carries its entry's fields on conv_diff, conv_gain, conv_chan, conv_xgain and conv_xchan.
- R3: An unmarked entry issues its conv_req one cycle after the arm write edge, or one cycle after the previous request. Consecutive unmarked entries therefore issue on consecutive cycles.
- R4: A marked entry waits for a pacer tick. The pacer reloads on arm and ticks every P cycles, so a marked first entry issues P cycles after the arm edge. The pacer keeps its period across scans.
- R5: The divisor is written at address 2 (bits 7:0), address 3 (bits 15:8) and address 4 (bits 23:16). P equals the divisor, but any value below MIN_DIV, including 0, gives P = MIN_DIV.
- R6: In one-shot mode (address 1, bit 2 = 0), scan_end pulses together with the request of the last queued entry. busy falls on that same edge.
- R7: In continuous mode (address 1, bit 2 = 1), the sequence wraps to entry 0 after the last entry and pulses scan_end on each pass. A stop command clears busy at its write edge and no request follows.
- R8: The command register is address 5, with bit 7 arm, bit 5 queue reset and bit 4 stop. All other bits have no effect. An arm is ignored while busy or when the queue is empty.
- R9: A queue reset empties the queue and ends any run at its write edge, so a following arm is ignored until new entries are written.
- R10: The queue holds DEPTH entries. Entries written beyond that are dropped.
- R11: conv_done is cleared by an accepted arm and set by the first request that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| busy | output | 1 | Sequence running |
| conv_req | output | 1 | One-cycle conversion request |
| conv_diff | output | 1 | Differential input select |
| conv_gain | output | 2 | Gain range |
| conv_chan | output | 4 | Channel |
| conv_xgain | output | 2 | External gain select |
| conv_xchan | output | 4 | External channel select |
| scan_end | output | 1 | Pulses with the last entry's request |
| conv_done | output | 1 | At least one conversion since the last arm |

## Verification
Command and register writes take effect on the clock edge that samples them. busy rises on the arm edge, and a stop or queue reset clears it on its own edge. An unmarked entry's request is due one edge after its trigger, while a marked entry's request is due exactly P edges after arm and every P edges after that. The bench drives and samples on falling edges and counts edges from the write edge. It samples both the cycle before a paced request is due and the cycle it is due, so a request that comes early or late is reported.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

   typedef struct packed {
      logic       diff;
      logic [1:0] gain;
      logic [3:0] chan;
      logic       start;
      logic [1:0] xgain;
      logic [3:0] xchan;
   } entry_t;

   localparam int ENTRY_W = $bits(entry_t);
   localparam int FIELD_W = ENTRY_W - 1;

   localparam logic [2:0] A_QUEUE  = 3'd0;
   localparam logic [2:0] A_CTRL   = 3'd1;
   localparam logic [2:0] A_DIV_LO = 3'd2;
   localparam logic [2:0] A_CMD    = 3'd5;

   localparam int C_ARM  = 7;
   localparam int C_RSTQ = 5;
   localparam int C_STOP = 4;
   localparam int K_CONT = 2;

endpackage

// File: rtl/scanseq_regs.sv
module scanseq_regs
   import scanseq_pkg::*;
#(
   parameter int PW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [7:0]    wr_data,
   output logic [PW-1:0] divisor,
   output logic          cont_mode,
   output logic          arm_p,
   output logic          stop_p,
   output logic          rstq_p,
   output logic          q_wr
);

   localparam int NB = (PW + 7) / 8;

   logic cmd_hit;

   assign cmd_hit = wr_en && (wr_addr == A_CMD);
   assign arm_p   = cmd_hit && wr_data[C_ARM];
   assign stop_p  = cmd_hit && wr_data[C_STOP];
   assign rstq_p  = cmd_hit && wr_data[C_RSTQ];
   assign q_wr    = wr_en && (wr_addr == A_QUEUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cont_mode <= 1'b0;
      else if (wr_en && wr_addr == A_CTRL)
         cont_mode <= wr_data[K_CONT];
   end

   for (genvar b = 0; b < NB; b++) begin : g_div
      localparam int LO = b * 8;
      localparam int BW = (PW - LO < 8) ? (PW - LO) : 8;
      logic [BW-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (wr_en && wr_addr == A_DIV_LO + 3'(b))
            byte_q <= wr_data[BW-1:0];
      end

      assign divisor[LO +: BW] = byte_q;
   end

endmodule

// File: rtl/scanseq_queue.sv
module scanseq_queue
   import scanseq_pkg::*;
#(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH),
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_stb,
   input  logic [6:0]    lo_bits,
   input  logic [6:0]    hi_bits,
   input  logic [AW-1:0] rd_addr,
   output entry_t        rd_entry,
   output logic [CW-1:0] count
);

   entry_t        mem [DEPTH];
   logic          half_q;
   logic [6:0]    lo_q;
   logic [CW-1:0] wcnt;
   logic          full;
   logic          commit;

   assign full   = (wcnt == CW'(DEPTH));
   assign commit = wr_stb && half_q && !full && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         lo_q   <= '0;
         wcnt   <= '0;
      end else if (clear) begin
         half_q <= 1'b0;
         wcnt   <= '0;
      end else if (wr_stb) begin
         if (!half_q) begin
            lo_q   <= lo_bits;
            half_q <= 1'b1;
         end else begin
            half_q <= 1'b0;
            if (!full)
               wcnt <= wcnt + CW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (commit)
         mem[wcnt[AW-1:0]] <= entry_t'({hi_bits, lo_q});
   end

   assign rd_entry = mem[rd_addr];
   assign count    = wcnt;

endmodule

// File: rtl/scanseq_pacer.sv
module scanseq_pacer #(
   parameter int PW      = 24,
   parameter int MIN_DIV = 50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] divisor,
   output logic          tick
);

   logic [PW-1:0] eff;
   logic [PW-1:0] cnt;

   assign eff = (divisor < PW'(MIN_DIV)) ? PW'(MIN_DIV) : divisor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= PW'(MIN_DIV);
      else if (!run || cnt == PW'(1))
         cnt <= eff;
      else
         cnt <= cnt - PW'(1);
   end

   assign tick = run && (cnt == PW'(1));

endmodule

// File: rtl/scanseq_engine.sv
module scanseq_engine
   import scanseq_pkg::*;
#(
   parameter int AW = 11,
   parameter int CW = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               stop,
   input  logic               rstq,
   input  logic               cont,
   input  logic               tick,
   input  logic [CW-1:0]      count,
   input  entry_t             entry,
   output logic [AW-1:0]      rd_addr,
   output logic               busy,
   output logic               req,
   output logic [FIELD_W-1:0] fields,
   output logic               eos,
   output logic               done
);

   logic [AW-1:0] ptr;
   logic          issue;
   logic          last;

   assign issue   = busy && (!entry.start || tick);
   assign last    = (CW'(ptr) == count - CW'(1));
   assign rd_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         ptr    <= '0;
         req    <= 1'b0;
         eos    <= 1'b0;
         done   <= 1'b0;
         fields <= '0;
      end else begin
         req <= 1'b0;
         eos <= 1'b0;
         if (stop || rstq) begin
            busy <= 1'b0;
            if (rstq)
               ptr <= '0;
         end else if (!busy) begin
            if (arm && count != '0) begin
               busy <= 1'b1;
               ptr  <= '0;
               done <= 1'b0;
            end
         end else if (issue) begin
            req    <= 1'b1;
            done   <= 1'b1;
            fields <= {entry.diff, entry.gain, entry.chan, entry.xgain, entry.xchan};
            if (last) begin
               eos <= 1'b1;
               ptr <= '0;
               if (!cont)
                  busy <= 1'b0;
            end else begin
               ptr <= ptr + AW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
   import scanseq_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int PW      = 24,
   parameter int MIN_DIV = 50
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       busy,
   output logic       conv_req,
   output logic       conv_diff,
   output logic [1:0] conv_gain,
   output logic [3:0] conv_chan,
   output logic [1:0] conv_xgain,
   output logic [3:0] conv_xchan,
   output logic       scan_end,
   output logic       conv_done
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("scan_sequencer: DEPTH must be at least 2");
   end
   if (PW < 9 || PW > 24) begin : g_bad_pw
      $error("scan_sequencer: PW must lie in 9..24");
   end
   if (MIN_DIV < 1 || MIN_DIV >= (1 << PW)) begin : g_bad_min
      $error("scan_sequencer: MIN_DIV out of range");
   end

   logic [PW-1:0]      divisor;
   logic               cont_mode;
   logic               arm_p;
   logic               stop_p;
   logic               rstq_p;
   logic               q_wr;
   logic               tick;
   logic [AW-1:0]      rd_addr;
   entry_t             rd_entry;
   logic [CW-1:0]      count;
   logic [FIELD_W-1:0] fields;

   scanseq_regs #(.PW(PW)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .divisor(divisor), .cont_mode(cont_mode), .arm_p(arm_p), .stop_p(stop_p),
      .rstq_p(rstq_p), .q_wr(q_wr)
   );

   scanseq_queue #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_queue (
      .clk(clk), .rst_n(rst_n), .clear(rstq_p), .wr_stb(q_wr),
      .lo_bits({wr_data[7], wr_data[5:0]}), .hi_bits(wr_data[6:0]),
      .rd_addr(rd_addr), .rd_entry(rd_entry), .count(count)
   );

   scanseq_pacer #(.PW(PW), .MIN_DIV(MIN_DIV)) i_pacer (
      .clk(clk), .rst_n(rst_n), .run(busy), .divisor(divisor), .tick(tick)
   );

   scanseq_engine #(.AW(AW), .CW(CW)) i_engine (
      .clk(clk), .rst_n(rst_n), .arm(arm_p), .stop(stop_p), .rstq(rstq_p),
      .cont(cont_mode), .tick(tick), .count(count), .entry(rd_entry),
      .rd_addr(rd_addr), .busy(busy), .req(conv_req), .fields(fields),
      .eos(scan_end), .done(conv_done)
   );

   assign {conv_diff, conv_gain, conv_chan, conv_xgain, conv_xchan} = fields;

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       busy,
   input logic       conv_req,
   input logic       scan_end,
   input logic       conv_done
);

   // R6: the end-of-scan pulse always accompanies a request
   a_r6_end_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      scan_end |-> conv_req);

   // R7: a stop write leaves the block idle with no request on the next cycle
   a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd5 && wr_data[4]) |=> (!busy && !conv_req));

   // R9: a queue reset ends the run at its write edge
   a_r9_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd5 && wr_data[5]) |=> !busy);

   // R3: requests only follow a cycle in which the sequence was running
   a_r3_req_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> $past(busy));

   // R11: the completion flag only rises together with a request
   a_r11_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_done) |-> conv_req);

endmodule

bind scan_sequencer scan_sequencer_chk i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .busy(busy), .conv_req(conv_req), .scan_end(scan_end), .conv_done(conv_done)
);

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int MIN_DIV    = 4;
   localparam int NVEC       = 5;

   // entry words (bits 15 and 6 set in some to show they are ignored)
   localparam logic [15:0] VEC_W [NVEC] = '{16'h0000, 16'h7F3F, 16'h2540, 16'hC912, 16'h1A2C};
   // expected {diff, gain, chan, xgain, xchan}
   localparam logic [12:0] VEC_E [NVEC] = '{
      {1'b0, 2'd0, 4'd0,  2'd0, 4'd0},
      {1'b1, 2'd3, 4'd15, 2'd3, 4'd15},
      {1'b0, 2'd2, 4'd5,  2'd0, 4'd0},
      {1'b1, 2'd0, 4'd9,  2'd1, 4'd2},
      {1'b0, 2'd1, 4'd10, 2'd2, 4'd12}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       busy, conv_req, conv_diff, scan_end, conv_done;
   logic [1:0] conv_gain, conv_xgain;
   logic [3:0] conv_chan, conv_xchan;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   scan_sequencer #(.DEPTH(DEPTH), .PW(24), .MIN_DIV(MIN_DIV)) i_scan_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .conv_req(conv_req), .conv_diff(conv_diff), .conv_gain(conv_gain),
      .conv_chan(conv_chan), .conv_xgain(conv_xgain), .conv_xchan(conv_xchan),
      .scan_end(scan_end), .conv_done(conv_done)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called at a falling edge; the write is sampled by the next rising edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic put(input logic [15:0] w);
      wr(3'd0, w[7:0]);
      wr(3'd0, w[15:8]);
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   function automatic int flds();
      return int'({conv_diff, conv_gain, conv_chan, conv_xgain, conv_xchan});
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "busy", busy, 0);
      chk("R1", "conv_req", conv_req, 0);
      chk("R1", "scan_end", scan_end, 0);
      chk("R1", "conv_done", conv_done, 0);

      // R2/R3/R6: vector table, unmarked entries, one-shot
      for (int i = 0; i < NVEC; i++) put(VEC_W[i]);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h80);
      chk("R8", "busy after arm", busy, 1);
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         chk("R3", "conv_req", conv_req, 1);
         chk("R2", "fields", flds(), int'(VEC_E[i]));
         chk("R6", "scan_end", scan_end, (i == NVEC - 1) ? 1 : 0);
         chk("R6", "busy", busy, (i == NVEC - 1) ? 0 : 1);
      end
      @(negedge clk);
      chk("R6", "req after pass", conv_req, 0);
      chk("R11", "done set", conv_done, 1);

      // R11: cleared by accepted arm
      wr(3'd5, 8'h80);
      chk("R11", "done cleared", conv_done, 0);
      wait_n(NVEC + 1);
      chk("R6", "idle after rerun", busy, 0);

      // R8: non-action bits ignored
      wr(3'd5, 8'h4F);
      chk("R8", "busy after other bits", busy, 0);
      @(negedge clk);
      chk("R8", "req after other bits", conv_req, 0);

      // R8: arm while busy ignored
      wr(3'd5, 8'h80);
      wr(3'd5, 8'h80);
      wait_n(NVEC - 1);
      chk("R8", "last req on time", conv_req, 1);
      chk("R8", "last chan", int'(conv_chan), 10);
      chk("R8", "scan_end on time", scan_end, 1);
      @(negedge clk);
      chk("R8", "idle after rearm", busy, 0);

      // R9: queue reset empties the queue
      wr(3'd5, 8'h20);
      wr(3'd5, 8'h80);
      chk("R9", "arm on empty ignored", busy, 0);

      // R4/R7: paced first entry, burst remainder, continuous
      put(16'h0180);
      put(16'h0200);
      put(16'h0300);
      wr(3'd2, 8'd10);
      wr(3'd3, 8'd0);
      wr(3'd4, 8'd0);
      wr(3'd1, 8'h04);
      wr(3'd5, 8'h80);
      wait_n(9);
      chk("R4", "no req before tick", conv_req, 0);
      @(negedge clk);
      chk("R4", "req at tick", conv_req, 1);
      chk("R4", "chan at tick", int'(conv_chan), 1);
      @(negedge clk);
      chk("R3", "burst chan 2", int'(conv_chan), 2);
      @(negedge clk);
      chk("R3", "burst chan 3", int'(conv_chan), 3);
      chk("R7", "scan_end pass 1", scan_end, 1);
      chk("R7", "busy in continuous", busy, 1);
      wait_n(7);
      chk("R7", "no req before 2nd tick", conv_req, 0);
      @(negedge clk);
      chk("R7", "wrap req", conv_req, 1);
      chk("R7", "wrap chan", int'(conv_chan), 1);
      wr(3'd5, 8'h10);
      chk("R7", "busy after stop", busy, 0);
      chk("R7", "no req after stop", conv_req, 0);
      wait_n(12);
      chk("R7", "quiet after stop", conv_req, 0);

      // R9: queue reset ends a running sequence
      wr(3'd5, 8'h80);
      wait_n(3);
      wr(3'd5, 8'h20);
      chk("R9", "busy after queue reset", busy, 0);

      // R5: divisor 0 clamps to MIN_DIV
      put(16'h0780);
      wr(3'd2, 8'd0);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h80);
      wait_n(MIN_DIV - 1);
      chk("R5", "no req before min period", conv_req, 0);
      @(negedge clk);
      chk("R5", "req at min period", conv_req, 1);
      chk("R6", "single entry scan_end", scan_end, 1);
      chk("R6", "single entry idle", busy, 0);

      // R5: middle byte gives 256
      wr(3'd3, 8'd1);
      wr(3'd5, 8'h80);
      wait_n(255);
      chk("R5", "no req before 256", conv_req, 0);
      @(negedge clk);
      chk("R5", "req at 256", conv_req, 1);
      chk("R5", "chan at 256", int'(conv_chan), 7);

      // R10: overflow entries dropped
      wr(3'd5, 8'h20);
      for (int i = 0; i <= DEPTH; i++) put(16'(i << 8));
      wr(3'd5, 8'h80);
      wait_n(DEPTH);
      chk("R10", "last stored chan", int'(conv_chan), DEPTH - 1);
      chk("R10", "scan_end at depth", scan_end, 1);
      @(negedge clk);
      chk("R10", "no extra req", conv_req, 0);
      chk("R10", "idle", busy, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule